// File: doc/BRIEF.md
# Trim Register Bank with Gated Commit

This block keeps four trim values for a data converter: a coarse and a fine offset trim, and a medium and a fine gain trim. Software writes them through a simple byte-wide register port. A write only changes a staging copy of the value. The trim outputs that feed the sample datapath come from a separate active copy. The active copy is refreshed from staging only while a single commit-enable bit is set.

The intended use has three steps. First, write every trim value with the enable bit at zero. Then raise the enable bit so the whole set is taken over together. Finally, clear the bit again. While the bit is clear, the datapath keeps the last applied trims, no matter how many writes arrive. This lets a multi-register update reach the datapath without passing through a half-written mix.

Register reads return the staged trim values and the enable bit. Any other address reads as zero.

Top module: `trim_commit_ctrl`

## Requirements
- R1: A synchronous active-low reset clears all four staged trims, all four active trims and the enable bit to zero.
- R2: A write (`cfg_we` high at a rising edge) to address 0x20, 0x21, 0x23 or 0x24 loads the coarse offset, fine offset, medium gain or fine gain staging register respectively at that edge. A read of the same address then returns the staged value on `cfg_rdata` combinationally.
- R3: While the enable bit is 0, the active trim outputs keep their values from one clock to the next, including across writes to the staging registers.
- R4: While the enable bit is 1, each active output takes the value its staging register held at the previous rising edge. A staging write at edge N therefore appears on the output after edge N+1.
- R5: The enable bit is bit 0 of address 0xFE. It is written from `cfg_wdata[0]`. A read of 0xFE returns the bit in position 0 and zero in bits 7:1, even after ones were written to those bits.
- R6: A write to any address other than the five above changes no staged, active or enable state. A read of such an address returns zero.
- R7: After the enable bit is cleared, the active outputs keep the values applied while it was set. Later staging writes do not reach them until the bit is set again.
- R8: A write to one trim address changes only that trim's staging register. The other three keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_we | input | 1 | Register write strobe, one cycle per write |
| cfg_addr | input | 8 | Register address for both write and read |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Combinational read data for `cfg_addr` |
| ofs_coarse_o | output | 8 | Active coarse offset trim |
| ofs_fine_o | output | 8 | Active fine offset trim |
| gain_med_o | output | 8 | Active medium gain trim |
| gain_fine_o | output | 8 | Active fine gain trim |

## Verification
The hardest state to reach from the ports is one where the staged and active copies differ while the enable bit is clear. Only from that state can the freeze of R3 and R7 be told apart from a plain register. The stimulus builds it in steps. It commits one set of trims, clears the enable bit, and then rewrites staging with different values. It then checks the outputs and the read port in the same cycle and sees the two copies disagree. A later re-enable, with a sample taken one cycle after a staging write, pins down the single-cycle lag of R4.

// File: rtl/trim_pkg.sv
// Package: shared constants and address map for the trim commit block.
// Assumes byte-wide registers and four trims in a fixed address order.
package trim_pkg;
    localparam int TRIM_N = 4;
    localparam int REG_W  = 8;
    localparam int ADR_W  = 8;

    localparam logic [ADR_W-1:0] EN_ADDR = 8'hFE;

    // Index order: 0 coarse offset, 1 fine offset, 2 medium gain, 3 fine gain.
    function automatic logic [ADR_W-1:0] trim_addr(input int idx);
        case (idx)
            0:       trim_addr = 8'h20;
            1:       trim_addr = 8'h21;
            2:       trim_addr = 8'h23;
            default: trim_addr = 8'h24;
        endcase
    endfunction
endpackage

// File: rtl/trim_stage_bank.sv
// Module: staging registers written by software.
// Assumes sel is one-hot or zero; each slot loads wdata on its own select.
module trim_stage_bank #(
    parameter int N = 4,
    parameter int W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic [N-1:0]        sel,
    input  logic [W-1:0]        wdata,
    output logic [N-1:0][W-1:0] stg
);
    for (genvar i = 0; i < N; i++) begin : g_slot
        // Load one staging slot on a selected write, clear on reset.
        always_ff @(posedge clk) begin
            if (!rst_n)
                stg[i] <= '0;
            else if (we && sel[i])
                stg[i] <= wdata;
        end
    end
endmodule

// File: rtl/trim_active_bank.sv
// Module: active trim registers seen by the datapath.
// Assumes a level-sensitive commit: every clock with en set copies staging.
module trim_active_bank #(
    parameter int N = 4,
    parameter int W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en,
    input  logic [N-1:0][W-1:0] stg,
    output logic [N-1:0][W-1:0] act
);
    // Copy all staged values while committing, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n)
            act <= '0;
        else if (en)
            act <= stg;
    end
endmodule

// File: rtl/trim_read_mux.sv
// Module: combinational register read path.
// Assumes unmapped addresses and unimplemented enable bits read as zero.
module trim_read_mux
    import trim_pkg::*;
#(
    parameter int N = 4,
    parameter int W = 8
) (
    input  logic [ADR_W-1:0]    addr,
    input  logic [N-1:0]        sel,
    input  logic [N-1:0][W-1:0] stg,
    input  logic                en,
    output logic [W-1:0]        rdata
);
    // Select the staged trim or the enable bit for the presented address.
    always_comb begin
        rdata = '0;
        for (int i = 0; i < N; i++)
            if (sel[i])
                rdata = stg[i];
        if (addr == EN_ADDR)
            rdata = {{(W-1){1'b0}}, en};
    end
endmodule

// File: rtl/trim_commit_ctrl.sv
// Module: top of the trim bank with gated commit.
// Decodes the register port, holds the commit-enable bit and exposes the
// active trims. Assumes single-cycle write strobes and a common clock.
module trim_commit_ctrl
    import trim_pkg::*;
#(
    parameter int DATA_W = REG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADR_W-1:0]  cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    output logic [DATA_W-1:0] ofs_coarse_o,
    output logic [DATA_W-1:0] ofs_fine_o,
    output logic [DATA_W-1:0] gain_med_o,
    output logic [DATA_W-1:0] gain_fine_o
);
    localparam int N = TRIM_N;

    logic [N-1:0]             sel;
    logic [N-1:0][DATA_W-1:0] stg;
    logic [N-1:0][DATA_W-1:0] act;
    logic                     en_q;

    // Address decode: one select per trim slot.
    for (genvar i = 0; i < N; i++) begin : g_dec
        assign sel[i] = (cfg_addr == trim_addr(i));
    end

    // Commit-enable register, bit 0 of the control address.
    always_ff @(posedge clk) begin
        if (!rst_n)
            en_q <= 1'b0;
        else if (cfg_we && cfg_addr == EN_ADDR)
            en_q <= cfg_wdata[0];
    end

    trim_stage_bank #(.N(N), .W(DATA_W)) u_stage (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .sel   (sel),
        .wdata (cfg_wdata),
        .stg   (stg)
    );

    trim_active_bank #(.N(N), .W(DATA_W)) u_active (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en_q),
        .stg   (stg),
        .act   (act)
    );

    trim_read_mux #(.N(N), .W(DATA_W)) u_rd (
        .addr  (cfg_addr),
        .sel   (sel),
        .stg   (stg),
        .en    (en_q),
        .rdata (cfg_rdata)
    );

    assign ofs_coarse_o = act[0];
    assign ofs_fine_o   = act[1];
    assign gain_med_o   = act[2];
    assign gain_fine_o  = act[3];
endmodule

// File: rtl/trim_commit_chk.sv
// Module: property checker bound to the trim commit top.
// Assumes it observes the top's ports plus its staging, active and enable state.
module trim_commit_chk
    import trim_pkg::*;
#(
    parameter int DATA_W = REG_W
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     cfg_we,
    input logic [ADR_W-1:0]         cfg_addr,
    input logic [DATA_W-1:0]        cfg_wdata,
    input logic [DATA_W-1:0]        cfg_rdata,
    input logic [TRIM_N-1:0][DATA_W-1:0] stg,
    input logic [TRIM_N-1:0][DATA_W-1:0] act,
    input logic                     en_q
);
    logic unmapped;
    assign unmapped = (cfg_addr != EN_ADDR) && (cfg_addr != trim_addr(0)) &&
                      (cfg_addr != trim_addr(1)) && (cfg_addr != trim_addr(2)) &&
                      (cfg_addr != trim_addr(3));

    p_stage_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr == trim_addr(0)) |=> (stg[0] == $past(cfg_wdata)));

    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |=> $stable(act));

    p_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        en_q |=> (act == $past(stg)));

    p_en_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_addr == EN_ADDR) |-> (cfg_rdata == {{(DATA_W-1){1'b0}}, en_q}));

    p_unmapped_r6: assert property (@(posedge clk) disable iff (!rst_n)
        unmapped |-> (cfg_rdata == '0));

    p_no_side_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && unmapped) |=> ($stable(stg) && $stable(en_q)));
endmodule

bind trim_commit_ctrl trim_commit_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .stg       (stg),
    .act       (act),
    .en_q      (en_q)
);

// File: tb/sim_trim_commit_ctrl.sv
// Bench: vector table for the commit sequence, then directed corner tests.
module sim_trim_commit_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_addr = 8'h00;
    logic [7:0] cfg_wdata = 8'h00;
    logic [7:0] cfg_rdata, ofs_coarse_o, ofs_fine_o, gain_med_o, gain_fine_o;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    trim_commit_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .ofs_coarse_o(ofs_coarse_o), .ofs_fine_o(ofs_fine_o),
        .gain_med_o(gain_med_o), .gain_fine_o(gain_fine_o)
    );

    function automatic logic [31:0] act_bus();
        return {gain_fine_o, gain_med_o, ofs_fine_o, ofs_coarse_o};
    endfunction

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    // Write one register; returns at the negedge after the write edge.
    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [7:0] exp);
        cfg_addr = a;
        #1;
        chk(req, {24'h0, cfg_rdata}, {24'h0, exp});
    endtask

    // Vector: {addr, wdata, expected read of addr, expected active bus}
    // Active bus packing: {gain_fine, gain_med, ofs_fine, ofs_coarse}.
    localparam int NV = 11;
    localparam logic [55:0] VEC [NV] = '{
        {8'h20, 8'h11, 8'h11, 32'h0000_0000},   // R2 R3 staged only
        {8'h21, 8'h22, 8'h22, 32'h0000_0000},   // R2 R8
        {8'h23, 8'h33, 8'h33, 32'h0000_0000},   // R2 R8
        {8'h24, 8'h44, 8'h44, 32'h0000_0000},   // R2 R3
        {8'hFE, 8'h01, 8'h01, 32'h4433_2211},   // R4 commit
        {8'h21, 8'h5A, 8'h5A, 32'h4433_5A11},   // R4 follow
        {8'hFE, 8'h00, 8'h00, 32'h4433_5A11},   // R7 freeze
        {8'h20, 8'h77, 8'h77, 32'h4433_5A11},   // R7 write not applied
        {8'h22, 8'hFF, 8'h00, 32'h4433_5A11},   // R6 unmapped
        {8'hFE, 8'hFF, 8'h01, 32'h4433_5A77},   // R5 upper bits read 0
        {8'hFE, 8'h00, 8'h00, 32'h4433_5A77}    // R7
    };

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 active after reset", act_bus(), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        rd_chk("R1 staged coarse offset", 8'h20, 8'h00);
        rd_chk("R1 staged fine gain", 8'h24, 8'h00);
        rd_chk("R1 enable bit", 8'hFE, 8'h00);

        for (int i = 0; i < NV; i++) begin
            wr(VEC[i][55:48], VEC[i][47:40]);
            @(negedge clk);
            chk($sformatf("vector %0d active", i), act_bus(), VEC[i][31:0]);
            rd_chk($sformatf("vector %0d read", i), VEC[i][55:48], VEC[i][39:32]);
        end

        // R6: unmapped write left every staged value untouched
        rd_chk("R6 coarse after unmapped write", 8'h20, 8'h77);
        rd_chk("R6 fine offset after unmapped write", 8'h21, 8'h5A);
        rd_chk("R6 medium gain after unmapped write", 8'h23, 8'h33);
        rd_chk("R6 fine gain after unmapped write", 8'h24, 8'h44);
        rd_chk("R6 unmapped read 0x25", 8'h25, 8'h00);

        // R3: staged and active differ while disabled
        wr(8'h23, 8'hC3);
        repeat (3) @(negedge clk);
        chk("R3 hold with pending stage", act_bus(), 32'h4433_5A77);
        rd_chk("R3 staged differs from active", 8'h23, 8'hC3);

        // R4: one-cycle lag from staging write to output
        wr(8'hFE, 8'h01);
        @(negedge clk);
        chk("R4 enable applies pending", act_bus(), 32'h44C3_5A77);
        wr(8'h24, 8'hE4);
        chk("R4 no change at write edge", act_bus(), 32'h44C3_5A77);
        @(negedge clk);
        chk("R4 follows one edge later", act_bus(), 32'hE4C3_5A77);

        // R1: reset mid-run clears everything
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R1 active after mid-run reset", act_bus(), 32'h0);
        rd_chk("R1 enable after mid-run reset", 8'hFE, 8'h00);
        rd_chk("R1 staged medium gain after reset", 8'h23, 8'h00);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule